// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes up to 24 interrupt request lines toward a downstream local interrupt controller. Software reaches all of its state through just two 32-bit bus locations. It first writes a register number into the select location. It then reads or writes the chosen register through the data window. Each request line owns a 64-bit routing entry. The entry's low word carries the vector, the delivery attributes and a mask bit. The entry's high word carries the destination.

When a request line rises and its entry is unmasked, the block records a pending request for that line. Pending requests leave one at a time over a valid/ready handshake, carrying the line's programmed vector. The lowest-numbered line goes first. One status bit in each low word is driven by hardware and shows whether that line still has a request waiting.

Top module: `irq_redirect_unit`

## Requirements
- R1: Bus offset 0x00 is the select register. It keeps only the low 8 bits of a write and reads back zero-extended. Any bus offset other than 0x00 and 0x10 reads as zero, and writes to it are ignored.
- R2: Select value 0x00 reaches the identification register. Its 4-bit field lives in bits 27:24, it resets to zero, and all other bits read as zero.
- R3: Select value 0x01 reaches the version register, which reads 0x00170011: version 0x11 in bits 7:0 and highest entry number 0x17 in bits 23:16. Writes to it change no register.
- R4: Select value 0x02 reaches the arbitration register. Its 4-bit field lives in bits 27:24, it resets to zero, and all other bits read as zero.
- R5: Select values from 0x10 upward address the table. The entry number is (select − 0x10) >> 1. An even select value reaches the low word and an odd value reaches the high word.
- R6: After reset every low word reads 0x00010000 (only the mask, bit 16, set) and every high word reads 0.
- R7: A write to a low word replaces every bit except bit 12 (delivery status) and bit 14 (remote IRR), which keep their values. A write to a high word replaces all 32 bits.
- R8: Select values 0x03–0x0F and table select values beyond the last entry read as zero, and writes through them change nothing.
- R9: A rising edge on a line whose entry has bit 16 clear yields exactly one transfer carrying that entry's vector (bits 7:0). A line held high yields no further transfers.
- R10: A rising edge on a line whose mask bit is set is dropped. It is not delivered later when the line is unmasked.
- R11: Pending requests leave lowest line first, one per accepted transfer. While valid is high and ready is low, valid and the vector hold steady.
- R12: Bit 12 of a line's low word reads 1 while that line has a request pending or on the handshake, and reads 0 once the request has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Bus offset (0x00 select, 0x10 window) |
| reg_wr | input | 1 | Bus write strobe |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Bus read data for the current offset |
| irq_in | input | 24 | Interrupt request lines |
| vec_valid | output | 1 | A vector is offered downstream |
| vec_ready | input | 1 | Downstream accepts the vector |
| vec_data | output | 8 | Vector being offered |

## Verification
Delivery is first tried with a single unmasked line that is raised and held. This separates edge detection from level detection, because a held line must not repeat. A masked line is then raised and unmasked afterwards, which shows whether masking is applied when the edge arrives or only when the request is delivered. Finally three lines rise together while downstream stalls. This exposes the delivery order and the hold-while-stalled rule, and it shows the per-line status bit turning on and then off. The register tests write all-ones patterns so that kept bits, reserved bits, out-of-range select values and the even/odd word split each show up in the read-back value.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
   localparam int REG_W     = 32;
   localparam int VEC_W     = 8;
   localparam int BIT_DSTAT = 12;
   localparam int BIT_RIRR  = 14;
   localparam int BIT_MASK  = 16;
   localparam logic [REG_W-1:0] LO_KEEP = (REG_W'(1) << BIT_DSTAT) | (REG_W'(1) << BIT_RIRR);
   localparam logic [REG_W-1:0] LO_RESET = REG_W'(1) << BIT_MASK;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ID,
      SEL_VER,
      SEL_ARB,
      SEL_LO,
      SEL_HI
   } win_sel_e;
endpackage

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
   import irq_redir_pkg::*;
#(
   parameter int NUM_LINES = 24,
   parameter logic [7:0] TBL_BASE = 8'h10,
   localparam int ENT_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic [7:0]       sel_idx,
   output win_sel_e         win_sel,
   output logic [ENT_W-1:0] win_ent
);
   logic [7:0] rel;

   always_comb begin
      rel     = sel_idx - TBL_BASE;
      win_sel = SEL_NONE;
      win_ent = '0;
      case (sel_idx)
         8'h00: win_sel = SEL_ID;
         8'h01: win_sel = SEL_VER;
         8'h02: win_sel = SEL_ARB;
         default: begin
            if (sel_idx >= TBL_BASE && {1'b0, rel[7:1]} < 8'(NUM_LINES)) begin
               win_sel = rel[0] ? SEL_HI : SEL_LO;
               win_ent = ENT_W'(rel[7:1]);
            end
         end
      endcase
   end
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
   import irq_redir_pkg::*;
#(
   parameter int NUM_LINES = 24,
   parameter int ADDR_W = 5,
   parameter logic [ADDR_W-1:0] WIN_OFS = 5'h10,
   parameter logic [7:0] TBL_BASE = 8'h10,
   parameter logic [7:0] VERSION = 8'h11,
   localparam int ENT_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic                       reg_wr,
   input  logic [REG_W-1:0]           reg_wdata,
   output logic [REG_W-1:0]           reg_rdata,
   input  logic [NUM_LINES-1:0]       line_busy,
   output logic [NUM_LINES-1:0]       line_mask,
   output logic [NUM_LINES*VEC_W-1:0] line_vec
);
   logic [7:0]       index_q;
   logic [3:0]       id_q;
   logic [3:0]       arb_q;
   logic [REG_W-1:0] lo_q [NUM_LINES];
   logic [REG_W-1:0] hi_q [NUM_LINES];
   win_sel_e         win_sel;
   logic [ENT_W-1:0] win_ent;
   logic             at_index;
   logic             at_window;
   logic             wr_win;

   irq_redir_decode #(
      .NUM_LINES (NUM_LINES),
      .TBL_BASE  (TBL_BASE)
   ) u_decode (
      .sel_idx (index_q),
      .win_sel (win_sel),
      .win_ent (win_ent)
   );

   assign at_index  = (reg_addr == '0);
   assign at_window = (reg_addr == WIN_OFS);
   assign wr_win    = reg_wr && at_window;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_q <= '0;
         id_q    <= '0;
         arb_q   <= '0;
         for (int i = 0; i < NUM_LINES; i++) begin
            lo_q[i] <= LO_RESET;
            hi_q[i] <= '0;
         end
      end else begin
         if (reg_wr && at_index) index_q <= reg_wdata[7:0];
         if (wr_win) begin
            case (win_sel)
               SEL_ID:  id_q  <= reg_wdata[27:24];
               SEL_ARB: arb_q <= reg_wdata[27:24];
               SEL_LO:  lo_q[win_ent] <= (reg_wdata & ~LO_KEEP) | (lo_q[win_ent] & LO_KEEP);
               SEL_HI:  hi_q[win_ent] <= reg_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (at_index) begin
         reg_rdata = {24'b0, index_q};
      end else if (at_window) begin
         case (win_sel)
            SEL_ID:  reg_rdata = {4'b0, id_q, 24'b0};
            SEL_VER: reg_rdata = {8'b0, 8'(NUM_LINES - 1), 8'b0, VERSION};
            SEL_ARB: reg_rdata = {4'b0, arb_q, 24'b0};
            SEL_LO:  reg_rdata = (lo_q[win_ent] & ~(REG_W'(1) << BIT_DSTAT))
                               | (REG_W'(line_busy[win_ent]) << BIT_DSTAT);
            SEL_HI:  reg_rdata = hi_q[win_ent];
            default: reg_rdata = '0;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_out
      assign line_vec[g*VEC_W +: VEC_W] = lo_q[g][VEC_W-1:0];
      assign line_mask[g] = lo_q[g][BIT_MASK];
   end

   p_index_low8_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && at_index) |=> (index_q == $past(reg_wdata[7:0])))
      else $error("R1 select register did not capture low byte");

   p_ver_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_win && win_sel == SEL_VER) |=> ($stable(id_q) && $stable(arb_q) && $stable(index_q)))
      else $error("R3 version write disturbed a register");
endmodule

// File: rtl/irq_redir_pend.sv
module irq_redir_pend
   import irq_redir_pkg::*;
#(
   parameter int NUM_LINES = 24,
   parameter int SYNC_STAGES = 0,
   localparam int ENT_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_LINES-1:0]       irq_in,
   input  logic [NUM_LINES-1:0]       line_mask,
   input  logic [NUM_LINES*VEC_W-1:0] line_vec,
   output logic [NUM_LINES-1:0]       line_busy,
   output logic                       vec_valid,
   input  logic                       vec_ready,
   output logic [VEC_W-1:0]           vec_data
);
   logic [NUM_LINES-1:0] irq_s;
   logic [NUM_LINES-1:0] irq_q;
   logic [NUM_LINES-1:0] pend_q;
   logic [NUM_LINES-1:0] rise;
   logic [NUM_LINES-1:0] take;
   logic [NUM_LINES-1:0] grant;
   logic [NUM_LINES-1:0] out_hot;
   logic [ENT_W-1:0]     grant_line;
   logic [ENT_W-1:0]     out_line_q;
   logic                 out_valid_q;
   logic [VEC_W-1:0]     out_data_q;
   logic                 load;

   if (SYNC_STAGES == 0) begin : g_direct
      assign irq_s = irq_in;
   end else begin : g_sync
      logic [NUM_LINES-1:0] stg_q [SYNC_STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) stg_q[s] <= '0;
         end else begin
            stg_q[0] <= irq_in;
            for (int s = 1; s < SYNC_STAGES; s++) stg_q[s] <= stg_q[s-1];
         end
      end
      assign irq_s = stg_q[SYNC_STAGES-1];
   end

   assign rise  = irq_s & ~irq_q;
   assign take  = rise & ~line_mask;
   assign grant = pend_q & (~pend_q + NUM_LINES'(1));
   assign load  = (|pend_q) && (!out_valid_q || vec_ready);

   always_comb begin
      grant_line = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (grant[i]) grant_line = ENT_W'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q       <= '0;
         pend_q      <= '0;
         out_valid_q <= 1'b0;
         out_data_q  <= '0;
         out_line_q  <= '0;
      end else begin
         irq_q  <= irq_s;
         pend_q <= (pend_q & ~(load ? grant : '0)) | take;
         if (load) begin
            out_valid_q <= 1'b1;
            out_data_q  <= line_vec[32'(grant_line)*VEC_W +: VEC_W];
            out_line_q  <= grant_line;
         end else if (vec_ready) begin
            out_valid_q <= 1'b0;
         end
      end
   end

   assign out_hot   = out_valid_q ? (NUM_LINES'(1) << out_line_q) : '0;
   assign line_busy = pend_q | out_hot;
   assign vec_valid = out_valid_q;
   assign vec_data  = out_data_q;

   p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data)))
      else $error("R11 offered vector changed while stalled");

   p_grant_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant))
      else $error("R11 more than one line granted");

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
      p_masked_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (rise[g] && line_mask[g] && !pend_q[g]) |=> !pend_q[g])
         else $error("R10 masked edge became pending");
      p_edge_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
         take[g] |=> pend_q[g])
         else $error("R9 unmasked edge not recorded");
   end
endmodule

// File: rtl/irq_redirect_unit.sv
module irq_redirect_unit
   import irq_redir_pkg::*;
#(
   parameter int NUM_LINES = 24,
   parameter int ADDR_W = 5,
   parameter logic [ADDR_W-1:0] WIN_OFS = 5'h10,
   parameter logic [7:0] TBL_BASE = 8'h10,
   parameter logic [7:0] VERSION = 8'h11,
   parameter int SYNC_STAGES = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [NUM_LINES-1:0] irq_in,
   output logic                 vec_valid,
   input  logic                 vec_ready,
   output logic [7:0]           vec_data
);
   localparam int TBL_SPAN = 2 * NUM_LINES;

   if (NUM_LINES < 1 || 32'(TBL_BASE) + TBL_SPAN > 256) begin : g_bad_lines
      $error("NUM_LINES does not fit in the 8-bit select space");
   end
   if (TBL_BASE < 8'h03) begin : g_bad_base
      $error("TBL_BASE overlaps the fixed registers");
   end
   if (WIN_OFS == '0) begin : g_bad_win
      $error("WIN_OFS must differ from the select offset");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic [NUM_LINES-1:0]       line_busy;
   logic [NUM_LINES-1:0]       line_mask;
   logic [NUM_LINES*VEC_W-1:0] line_vec;

   irq_redir_regs #(
      .NUM_LINES (NUM_LINES),
      .ADDR_W    (ADDR_W),
      .WIN_OFS   (WIN_OFS),
      .TBL_BASE  (TBL_BASE),
      .VERSION   (VERSION)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .line_busy (line_busy),
      .line_mask (line_mask),
      .line_vec  (line_vec)
   );

   irq_redir_pend #(
      .NUM_LINES   (NUM_LINES),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .line_mask (line_mask),
      .line_vec  (line_vec),
      .line_busy (line_busy),
      .vec_valid (vec_valid),
      .vec_ready (vec_ready),
      .vec_data  (vec_data)
   );
endmodule

// File: tb/irq_redirect_unit_bench.sv
module irq_redirect_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [23:0] irq_in = '0;
   logic        vec_valid;
   logic        vec_ready = 1'b0;
   logic [7:0]  vec_data;

   int n_checks = 0;
   int n_fail = 0;
   logic [7:0] exp_q [$];

   always #2.5 clk = ~clk;

   irq_redirect_unit u_irq_redirect_unit (
      .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr (reg_wr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq_in (irq_in),
      .vec_valid (vec_valid), .vec_ready (vec_ready), .vec_data (vec_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
      @(posedge clk); #1;
      reg_addr = a; reg_wr = 1'b0;
      @(negedge clk);
      d = reg_rdata;
   endtask

   task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
      bus_wr(5'h00, {24'b0, idx});
      bus_wr(5'h10, d);
   endtask

   task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
      bus_wr(5'h00, {24'b0, idx});
      bus_rd(5'h10, d);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // Scoreboard monitor: a transfer happens at the next edge when valid and ready are both high
   always @(negedge clk) begin
      if (rst_n && vec_valid && vec_ready) begin
         if (exp_q.size() == 0) begin
            check("R9/R10 unexpected transfer", {24'b0, vec_data}, 32'hFFFF_FFFF);
         end else begin
            check("R9/R11 delivered vector", {24'b0, vec_data}, {24'b0, exp_q.pop_front()});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] r;
      idle(4);
      rst_n = 1'b1;
      idle(2);

      // Reset state
      check("R11 valid low after reset", {31'b0, vec_valid}, 32'h0);
      bus_rd(5'h00, r);           check("R1 select reset", r, 32'h0);
      win_rd(8'h00, r);           check("R2 id reset", r, 32'h0);
      win_rd(8'h01, r);           check("R3 version value", r, 32'h0017_0011);
      win_rd(8'h02, r);           check("R4 arb reset", r, 32'h0);
      win_rd(8'h10, r);           check("R6 entry0 low reset", r, 32'h0001_0000);
      win_rd(8'h3E, r);           check("R6 entry23 low reset", r, 32'h0001_0000);
      win_rd(8'h3F, r);           check("R6 entry23 high reset", r, 32'h0);

      // Select register width and stray offsets
      bus_wr(5'h00, 32'h1234_5678);
      bus_rd(5'h00, r);           check("R1 select keeps low byte", r, 32'h0000_0078);
      bus_wr(5'h08, 32'hFFFF_FFFF);
      bus_rd(5'h00, r);           check("R1 stray write ignored", r, 32'h0000_0078);
      bus_rd(5'h08, r);           check("R1 stray offset reads zero", r, 32'h0);

      // Fixed registers
      win_wr(8'h00, 32'hFFFF_FFFF);
      win_rd(8'h00, r);           check("R2 id field only", r, 32'h0F00_0000);
      win_wr(8'h01, 32'h0);
      win_rd(8'h01, r);           check("R3 version unchanged", r, 32'h0017_0011);
      win_rd(8'h00, r);           check("R3 id untouched by version write", r, 32'h0F00_0000);
      win_wr(8'h02, 32'hA5FF_FFFF);
      win_rd(8'h02, r);           check("R4 arb field only", r, 32'h0500_0000);

      // Table words
      win_wr(8'h1A, 32'hFFFF_FFFF);
      win_rd(8'h1A, r);           check("R7 low write keeps bits 12 and 14", r, 32'hFFFF_AFFF);
      win_wr(8'h1B, 32'hDEAD_BEEF);
      win_rd(8'h1B, r);           check("R7 high write whole word", r, 32'hDEAD_BEEF);
      win_rd(8'h1A, r);           check("R5 low untouched by high write", r, 32'hFFFF_AFFF);
      win_rd(8'h19, r);           check("R5 neighbour entry high", r, 32'h0);
      win_wr(8'h3F, 32'h1234_5678);
      win_rd(8'h3F, r);           check("R5 last entry high", r, 32'h1234_5678);

      // Undefined select values
      win_wr(8'h05, 32'hFFFF_FFFF);
      win_rd(8'h05, r);           check("R8 gap select reads zero", r, 32'h0);
      win_wr(8'h40, 32'hFFFF_FFFF);
      win_rd(8'h40, r);           check("R8 past-table select reads zero", r, 32'h0);
      win_rd(8'h3E, r);           check("R8 last entry untouched", r, 32'h0001_0000);
      win_rd(8'h10, r);           check("R8 first entry untouched", r, 32'h0001_0000);

      // Single line delivery, level held
      vec_ready = 1'b1;
      win_wr(8'h16, 32'h0000_0033);
      exp_q.push_back(8'h33);
      irq_in[3] = 1'b1;
      idle(12);
      irq_in[3] = 1'b0;
      idle(4);
      check("R9 one transfer for held line", exp_q.size(), 32'd0);

      // Masked line then unmasked
      irq_in[7] = 1'b1;
      idle(8);
      win_wr(8'h1E, 32'h0000_0077);
      idle(8);
      check("R10 masked edge not delivered", exp_q.size(), 32'd0);
      irq_in[7] = 1'b0;
      idle(2);
      exp_q.push_back(8'h77);
      irq_in[7] = 1'b1;
      idle(8);
      check("R10 unmasked edge delivered", exp_q.size(), 32'd0);

      // Priority and stall
      vec_ready = 1'b0;
      win_wr(8'h14, 32'h0000_0022);
      win_wr(8'h22, 32'h0000_0099);
      win_wr(8'h38, 32'h0000_00A0);
      exp_q.push_back(8'h22);
      exp_q.push_back(8'h99);
      exp_q.push_back(8'hA0);
      irq_in[20] = 1'b1; irq_in[9] = 1'b1; irq_in[2] = 1'b1;
      idle(5);
      check("R11 stalled valid", {31'b0, vec_valid}, 32'h1);
      check("R11 lowest line first", {24'b0, vec_data}, 32'h22);
      win_rd(8'h22, r);           check("R12 status set while waiting", r, 32'h0000_1099);
      win_rd(8'h16, r);           check("R12 idle line status clear", r, 32'h0000_0033);
      check("R11 vector held over stall", {24'b0, vec_data}, 32'h22);
      vec_ready = 1'b1;
      idle(10);
      check("R11 all queued delivered", exp_q.size(), 32'd0);
      win_rd(8'h22, r);           check("R12 status clear after accept", r, 32'h0000_0099);
      check("R11 valid low when drained", {31'b0, vec_valid}, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule